// File: doc/BRIEF.md
# Stack Push/Pop Sequencer for Byte-Wide Memory

This block owns a 16-bit stack pointer and moves 16-bit register pairs between a core and a memory that is one byte wide. A core presents one command at a time: push a word, pop a word, load the stack pointer, or store the stack pointer at a given address. The block then runs the byte transfers on a simple synchronous memory port and raises a one-cycle done pulse when it finishes. A pop also returns the assembled word with that pulse. Return-from-subroutine is a pop whose word goes to the program counter, and a call is a push of the return address. The core handles both of these, so the block sees only plain push and pop commands.

The stack grows downward. On a push the high byte goes to the higher address and is written first. On a pop the low byte is read first, from the lower address. When the pair is the accumulator/flags pair, the block packs the four condition flags into the top nibble of the low byte and keeps the lower nibble at zero, in both directions. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_value` is 16'hFFFE, and `busy`, `done` and `mem_we` are all low.
- R2: A push (`cmd_op` = 0) starting from pointer S writes `cmd_data[15:8]` to address S-1 and then writes `cmd_data[7:0]` to address S-2, in that order. It leaves `sp_value` at S-2.
- R3: A push with `cmd_flags` high writes a low byte made of `cmd_data[7:4]` in bits 7..4 (zero, subtract, half-carry and carry, from bit 7 down) and zeros in bits 3..0.
- R4: A pop (`cmd_op` = 1) starting from pointer S reads the low byte at S and the high byte at S+1. During the done cycle `rsp_data` carries {byte at S+1, byte at S}, and `sp_value` is left at S+2.
- R5: A pop with `cmd_flags` high returns bits 3..0 of `rsp_data` as zero, whatever the memory holds.
- R6: `busy` rises in the cycle after a command is accepted and stays high until the cycle that carries `done`, which is its last high cycle. The number of busy cycles is 4 for a push, 3 for a pop, 1 for a pointer load and 5 for a pointer store.
- R7: A pointer store (`cmd_op` = 3) writes `sp_value[7:0]` at address `cmd_data` and then `sp_value[15:8]` at `cmd_data`+1. The pointer does not change.
- R8: A pointer load (`cmd_op` = 2) sets `sp_value` to `cmd_data`, and no memory write takes place.
- R9: All pointer and address arithmetic wraps modulo 65536 and gives no fault indication. For example, a push from pointer 0001 writes to 0000 and then FFFF.
- R10: A command presented while `busy` is high is ignored. It has no effect on the pointer or on memory, and it produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_op | input | 2 | 0 push, 1 pop, 2 pointer load, 3 pointer store |
| cmd_data | input | 16 | Word to push, new pointer, or store address |
| cmd_flags | input | 1 | Pair is the accumulator/flags pair |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Popped word, valid with done after a pop |
| sp_value | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read byte for the address of the previous cycle |

## Verification
An off-by-one in the pointer sequencing shows up on `mem_addr` during the first write of a push, or as a byte-swapped `rsp_data` at the end of a pop. Either appears within four cycles of the command. A sequencer stuck in the wrong state shows up as a wrong busy-cycle count or a missing done pulse on that same command. A stale packed-flag register would corrupt the low nibble of a write or a read on the very next flags-pair transfer. The wrap cases at 0000/FFFF and commands issued while busy are exercised separately, because a fault in either one stays hidden in ordinary traffic.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_LDSP = 2'd2,
    OP_STSP = 2'd3
  } stk_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PU_DEC,
    S_PU_HI,
    S_PU_LO,
    S_PO_LO,
    S_PO_HI,
    S_ST_W0,
    S_ST_W1,
    S_ST_LO,
    S_ST_HI,
    S_DONE
  } stk_state_e;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // asserts immediately, releases after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int                WORD_W   = 16,
  parameter logic [WORD_W-1:0] SP_RESET = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  output logic [WORD_W-1:0] sp
);

  logic [WORD_W-1:0] sp_d;
  logic              sp_en;

  assign sp_en = load | inc | dec;

  // wrap-around is natural modulo 2**WORD_W
  always_comb begin
    sp_d = sp;
    if (load)     sp_d = load_val;
    else if (inc) sp_d = sp + 1'b1;
    else if (dec) sp_d = sp - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp <= SP_RESET;
    else if (sp_en) sp <= sp_d;
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  stk_op_e    cmd_op,
  output stk_state_e state,
  output stk_op_e    op_q,
  output logic       accept,
  output logic       sp_inc,
  output logic       sp_dec,
  output logic       sp_load,
  output logic       busy,
  output logic       done
);

  stk_state_e state_d;

  assign accept  = cmd_valid && (state == S_IDLE);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);
  assign sp_dec  = (state == S_PU_DEC) || (state == S_PU_HI);
  assign sp_inc  = (state == S_PO_LO)  || (state == S_PO_HI);
  assign sp_load = accept && (cmd_op == OP_LDSP);

  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE: begin
        if (cmd_valid) begin
          unique case (cmd_op)
            OP_PUSH: state_d = S_PU_DEC;
            OP_POP:  state_d = S_PO_LO;
            OP_LDSP: state_d = S_DONE;
            OP_STSP: state_d = S_ST_W0;
          endcase
        end
      end
      S_PU_DEC: state_d = S_PU_HI;
      S_PU_HI:  state_d = S_PU_LO;
      S_PU_LO:  state_d = S_DONE;
      S_PO_LO:  state_d = S_PO_HI;
      S_PO_HI:  state_d = S_DONE;
      S_ST_W0:  state_d = S_ST_W1;
      S_ST_W1:  state_d = S_ST_LO;
      S_ST_LO:  state_d = S_ST_HI;
      S_ST_HI:  state_d = S_DONE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_q <= OP_PUSH;
    else if (accept) op_q <= cmd_op;
  end

endmodule

// File: rtl/stk_data.sv
module stk_data
  import stk_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int FLAG_BITS = 4,
  localparam int BYTE_W   = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  stk_op_e           cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_flags,
  input  stk_state_e        state,
  input  stk_op_e           op_q,
  input  logic [WORD_W-1:0] sp,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [WORD_W-1:0] rsp_data
);

  localparam int LOW_W = BYTE_W - FLAG_BITS;

  function automatic logic [BYTE_W-1:0] keep_flags(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-1:LOW_W], {LOW_W{1'b0}}};
  endfunction

  logic [WORD_W-1:0] word_q, word_d, res_q, live_word;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              flag_q, pop_done, lo_en;

  assign word_d = (cmd_flags && cmd_op == OP_PUSH)
                ? {cmd_data[WORD_W-1:BYTE_W], keep_flags(cmd_data[BYTE_W-1:0])}
                : cmd_data;
  assign lo_en     = (state == S_PO_HI);
  assign lo_d      = flag_q ? keep_flags(mem_rdata) : mem_rdata;
  assign pop_done  = (state == S_DONE) && (op_q == OP_POP);
  assign live_word = {mem_rdata, lo_q};
  assign rsp_data  = pop_done ? live_word : res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      flag_q <= 1'b0;
    end else if (accept) begin
      word_q <= word_d;
      flag_q <= cmd_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (pop_done) res_q <= live_word;
  end

  always_comb begin
    mem_addr  = sp;
    mem_wdata = '0;
    mem_we    = 1'b0;
    unique case (state)
      S_PU_HI: begin mem_we = 1'b1; mem_wdata = word_q[WORD_W-1:BYTE_W]; end
      S_PU_LO: begin mem_we = 1'b1; mem_wdata = word_q[BYTE_W-1:0]; end
      S_ST_LO: begin mem_we = 1'b1; mem_addr = word_q; mem_wdata = sp[BYTE_W-1:0]; end
      S_ST_HI: begin mem_we = 1'b1; mem_addr = word_q + 1'b1; mem_wdata = sp[WORD_W-1:BYTE_W]; end
      default: ;
    endcase
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
#(
  parameter int                WORD_W      = 16,
  parameter int                FLAG_BITS   = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] SP_RESET    = 16'hFFFE,
  localparam int               BYTE_W      = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_flags,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rsp_data,
  output logic [WORD_W-1:0] sp_value,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata
);

  logic       rst_sync_n, accept, sp_inc, sp_dec, sp_load;
  stk_state_e state;
  stk_op_e    op_q, op_in;

  assign op_in = stk_op_e'(cmd_op);

  stk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  stk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(op_in),
    .state(state), .op_q(op_q), .accept(accept), .sp_inc(sp_inc),
    .sp_dec(sp_dec), .sp_load(sp_load), .busy(busy), .done(done)
  );

  stk_sp_reg #(.WORD_W(WORD_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_sync_n), .inc(sp_inc), .dec(sp_dec),
    .load(sp_load), .load_val(cmd_data), .sp(sp_value)
  );

  stk_data #(.WORD_W(WORD_W), .FLAG_BITS(FLAG_BITS)) u_data (
    .clk(clk), .rst_n(rst_sync_n), .accept(accept), .cmd_op(op_in),
    .cmd_data(cmd_data), .cmd_flags(cmd_flags), .state(state), .op_q(op_q),
    .sp(sp_value), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .rsp_data(rsp_data)
  );

  a_r6_done_while_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> busy);

  a_r6_release_after_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !busy);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !done) |=> busy);

  a_r2_low_byte_below_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == S_PU_LO) |-> (mem_we && mem_addr == WORD_W'($past(mem_addr) - 1'b1)));

  a_r4_pop_steps_up: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == S_PO_HI) |-> (sp_value == WORD_W'($past(sp_value) + 1'b1)));

  a_r7_pointer_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == S_ST_LO || state == S_ST_HI) |-> $stable(sp_value));

endmodule

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'h0;
  logic        cmd_flags = 1'b0;
  logic        busy, done, mem_we;
  logic [15:0] rsp_data, sp_value, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int vecs = 0;
  int fails = 0;
  bit mon_en = 1'b0;
  int cyc = 0;

  logic [15:0] m_sp;
  logic [7:0]  dmem [int];
  logic [7:0]  ref_mem [int];
  logic [23:0] q_wr [$];
  string       q_wr_tag [$];
  int          q_cyc [$];
  logic [15:0] q_sp [$];
  logic [16:0] q_rsp [$];
  string       q_tag [$];

  always #2 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_flags(cmd_flags), .busy(busy), .done(done),
    .rsp_data(rsp_data), .sp_value(sp_value), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  // synchronous byte memory, read data one cycle after the address
  always @(posedge clk) begin
    if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    q_wr.push_back({a, d});
    q_wr_tag.push_back(tag);
    ref_mem[int'(a)] = d;
  endtask

  // scoreboard driver side: expectations computed from the requirements
  task automatic model(input logic [1:0] op, input logic [15:0] d,
                       input bit fl, input string tag);
    logic [7:0]  lo, hi;
    logic [15:0] a2;
    int          n;
    logic [16:0] r;
    r = 17'h0;
    n = 0;
    case (op)
      2'd0: begin
        lo = fl ? {d[7:4], 4'h0} : d[7:0];
        m_sp = m_sp - 16'd1; exp_wr(m_sp, d[15:8], tag);
        m_sp = m_sp - 16'd1; exp_wr(m_sp, lo, tag);
        n = 4;
      end
      2'd1: begin
        lo = rd_ref(m_sp); m_sp = m_sp + 16'd1;
        hi = rd_ref(m_sp); m_sp = m_sp + 16'd1;
        if (fl) lo = lo & 8'hF0;
        r = {1'b1, hi, lo};
        n = 3;
      end
      2'd2: begin
        m_sp = d;
        n = 1;
      end
      default: begin
        a2 = d + 16'd1;
        exp_wr(d, m_sp[7:0], tag);
        exp_wr(a2, m_sp[15:8], tag);
        n = 5;
      end
    endcase
    q_cyc.push_back(n);
    q_sp.push_back(m_sp);
    q_rsp.push_back(r);
    q_tag.push_back(tag);
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] d, input bit fl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_flags = fl;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_flags = 1'b0;
  endtask

  task automatic run(input logic [1:0] op, input logic [15:0] d,
                     input bit fl, input string tag);
    model(op, d, fl, tag);
    send(op, d, fl);
    while (busy) @(negedge clk);
  endtask

  // monitor side: compares results as they appear at the ports
  always @(negedge clk) begin
    if (mon_en) begin
      if (busy) cyc++;
      if (mem_we) begin
        if (q_wr.size() == 0) begin
          chk(1'b0, "R10", "unexpected write", {mem_addr, mem_wdata}, 32'h0);
        end else begin
          logic [23:0] e;
          string t;
          e = q_wr.pop_front();
          t = q_wr_tag.pop_front();
          chk({mem_addr, mem_wdata} == e, t, "write addr/data", {mem_addr, mem_wdata}, e);
        end
      end
      if (done) begin
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
        end else begin
          int          ec;
          logic [15:0] es;
          logic [16:0] er;
          string       t;
          ec = q_cyc.pop_front();
          es = q_sp.pop_front();
          er = q_rsp.pop_front();
          t  = q_tag.pop_front();
          chk(cyc == ec, "R6", "busy cycles", cyc, ec);
          chk(sp_value == es, t, "stack pointer", sp_value, es);
          if (er[16]) chk(rsp_data == er[15:0], t, "popped word", rsp_data, er[15:0]);
        end
        cyc = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual hung expected idle");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sp_value == 16'hFFFE, "R1", "reset pointer", sp_value, 16'hFFFE);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(mem_we == 1'b0, "R1", "reset write enable", mem_we, 0);
    m_sp = 16'hFFFE;
    mon_en = 1'b1;

    run(2'd0, 16'hBEEF, 1'b0, "R2");
    run(2'd1, 16'h0000, 1'b0, "R4");
    run(2'd0, 16'h12F7, 1'b1, "R3");
    run(2'd1, 16'h0000, 1'b1, "R5");
    run(2'd0, 16'h34AB, 1'b0, "R2");
    run(2'd1, 16'h0000, 1'b1, "R5");
    run(2'd0, 16'h1357, 1'b0, "R2");
    run(2'd0, 16'h2468, 1'b0, "R2");
    run(2'd1, 16'h0000, 1'b0, "R4");
    run(2'd1, 16'h0000, 1'b0, "R4");
    // wrap through address zero
    run(2'd2, 16'h0001, 1'b0, "R8");
    run(2'd0, 16'hCAFE, 1'b0, "R9");
    run(2'd1, 16'h0000, 1'b0, "R9");
    run(2'd2, 16'hFFFF, 1'b0, "R8");
    run(2'd1, 16'h0000, 1'b0, "R9");
    // pointer store, plain and wrapping
    run(2'd2, 16'h1234, 1'b0, "R8");
    run(2'd3, 16'h8000, 1'b0, "R7");
    run(2'd3, 16'hFFFF, 1'b0, "R7");
    run(2'd1, 16'h0000, 1'b0, "R9");
    // R10: a load held while a push is in flight is ignored
    run(2'd2, 16'h4000, 1'b0, "R8");
    model(2'd0, 16'h5A5A, 1'b0, "R10");
    send(2'd0, 16'h5A5A, 1'b0);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 16'h1234;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sp_value == m_sp, "R10", "pointer after ignored load", sp_value, m_sp);
    run(2'd1, 16'h0000, 1'b0, "R10");

    repeat (2) @(negedge clk);
    chk(q_wr.size() == 0, "R2", "writes left outstanding", q_wr.size(), 0);
    chk(q_cyc.size() == 0, "R6", "done pulses missing", q_cyc.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule